// File: doc/BRIEF.md
# Parallel ROM Read Controller

This block sits between a synchronous host and an external asynchronous parallel mask ROM. The memory holds 8M sixteen-bit words or, read a byte at a time, 16M bytes. The host offers one read at a time with a valid/ready handshake: a byte address and a mode flag. The controller answers with a one-cycle response strobe and the fetched data. On the memory side it drives the word address bus, an active-low chip select, an active-low output enable and a word/byte select. It also owns the one shared pin that is the top data bit in word mode and the lowest address bit in byte mode.

All memory timing is counted in clock cycles. The access time, the output-enable time and the bus turnaround after a read are parameters, rounded up to whole cycles. The controller presents the address, waits until the slower of the address access and the output-enable delay has passed, and samples the data bus before it touches the address again. Chip select stays low between reads, so back-to-back reads only pay the access time. After a configurable run of idle cycles the controller raises chip select and puts the memory into standby.

In byte mode the controller drives the shared pin with the byte address LSB and ignores it as data. It also discards the upper data lane. The response is zero-extended so the host always sees 16 bits.

Top module: `prom_read_ctrl`

## Requirements
- R1: After reset, chip select and output enable are high, the shared pin is released (`mem_lsb_oe`=0), `rsp_valid` is 0 and, once the internal reset has been released, `req_ready` is 1.
- R2: `req_ready` is 0 from the cycle after a request is accepted until the turnaround after that read has ended, so only one read is outstanding.
- R3: A word read (`req_byte`=0) drives `mem_addr` with `req_addr[23:1]` (bit 0 is ignored) and `mem_byte_n`=1. It returns all 16 data lines unchanged in `rsp_data`.
- R4: A byte read (`req_byte`=1) drives `mem_addr` with `req_addr[23:1]`, `mem_byte_n`=0 and the shared pin with `req_addr[0]` (`mem_lsb_oe`=1). It returns `{8'h00, mem_dq_in[7:0]}`, so data lines 8 to 15 never reach the host.
- R5: In a word read the shared pin is released in every cycle of the read. This includes the cycle before output enable falls.
- R6: The address and controls are set one cycle before output enable falls. The data is captured at the end of cycle WAIT-1 counted from the accepting edge, where WAIT = max(T_ACC, T_OE+1), and `rsp_valid` rises exactly WAIT cycles after that edge, in the cycle output enable returns high.
- R7: Every accepted request produces exactly one single-cycle `rsp_valid` pulse.
- R8: After capture, output enable stays high and the address stays unchanged for T_TURN cycles before `req_ready` returns.
- R9: Between back-to-back reads issued before the idle limit, chip select remains low.
- R10: After IDLE_CYC consecutive idle cycles with no request, chip select goes high (standby). A later request starts a full-length read from standby.
- R11: Output enable is never low while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host read request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | ADDR_W (24) | Byte address of the read |
| req_byte | input | 1 | 1 = byte read, 0 = word read |
| rsp_valid | output | 1 | One-cycle strobe: read data valid |
| rsp_data | output | DATA_W (16) | Read data, zero-extended in byte mode |
| mem_addr | output | ADDR_W-1 (23) | Memory word address bus |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_byte_n | output | 1 | Word/byte select: 1 word, 0 byte |
| mem_dq_in | input | DATA_W (16) | Memory data bus as seen by the controller |
| mem_lsb_out | output | 1 | Value driven onto the shared top data pin |
| mem_lsb_oe | output | 1 | Drive enable for the shared top data pin |

## Verification
The hardest situation to expose is a capture taken even one cycle early. From the ports it looks like a correct read unless the memory punishes it. The bench's memory model therefore tracks how many whole cycles the address, select lines and output enable have been stable. It returns a junk pattern until both the access and the output-enable windows are met, and in byte mode it also places junk on the upper lane and on the shared pin. Reads then alternate word and byte modes at both ends of the address space, are issued back to back and after a standby period, so a premature sample, a missed mask or a late pin release each show up as wrong data.

// File: rtl/prom_rd_pkg.sv
package prom_rd_pkg;

  typedef enum logic [2:0] {
    ST_SLEEP  = 3'd0,
    ST_IDLE   = 3'd1,
    ST_SETUP  = 3'd2,
    ST_ACCESS = 3'd3,
    ST_TURN   = 3'd4
  } rd_state_e;

  function automatic int unsigned imax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/prom_rd_cnt.sv
module prom_rd_cnt #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] q
);

  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (clr) begin
      q_nxt = '0;
    end else if (en) begin
      q_nxt = q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= q_nxt;
    end
  end

endmodule

// File: rtl/prom_rd_seq.sv
module prom_rd_seq
  import prom_rd_pkg::*;
#(
  parameter int unsigned T_ACC    = 10,
  parameter int unsigned T_OE     = 3,
  parameter int unsigned T_TURN   = 2,
  parameter int unsigned IDLE_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  output logic req_ready,
  output logic accept,
  output logic capture,
  output logic in_cycle,
  output logic ce_n,
  output logic oe_n
);

  localparam int unsigned WAIT  = imax(T_ACC, T_OE + 1);
  localparam int unsigned PH_W  = $clog2(imax(WAIT, T_TURN) + 1);
  localparam int unsigned ID_W  = $clog2(IDLE_CYC + 1);
  localparam logic [PH_W-1:0] PH_CAP  = PH_W'(WAIT - 1);
  localparam logic [PH_W-1:0] PH_TEND = PH_W'(T_TURN - 1);
  localparam logic [ID_W-1:0] ID_END  = ID_W'(IDLE_CYC - 1);

  rd_state_e       state, nxt;
  logic [PH_W-1:0] ph_q;
  logic [ID_W-1:0] idle_q;
  logic            ready_q, ce_n_q, oe_n_q;
  logic            ph_clr, ph_en, id_clr, id_en;

  assign accept   = req_valid & ready_q;
  assign capture  = (state == ST_ACCESS) && (ph_q == PH_CAP);
  assign in_cycle = (state == ST_SETUP) || (state == ST_ACCESS) || (state == ST_TURN);

  assign ph_clr = accept | capture;
  assign ph_en  = in_cycle;
  assign id_clr = (state != ST_IDLE);
  assign id_en  = (state == ST_IDLE);

  prom_rd_cnt #(.W(PH_W)) phase_cnt_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ph_clr),
    .en    (ph_en),
    .q     (ph_q)
  );

  prom_rd_cnt #(.W(ID_W)) idle_cnt_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (id_clr),
    .en    (id_en),
    .q     (idle_q)
  );

  always_comb begin
    nxt = state;
    unique case (state)
      ST_SLEEP: begin
        if (accept) nxt = ST_SETUP;
      end
      ST_IDLE: begin
        if (accept) begin
          nxt = ST_SETUP;
        end else if (idle_q == ID_END) begin
          nxt = ST_SLEEP;
        end
      end
      ST_SETUP:  nxt = ST_ACCESS;
      ST_ACCESS: begin
        if (ph_q == PH_CAP) nxt = ST_TURN;
      end
      ST_TURN: begin
        if (ph_q == PH_TEND) nxt = ST_IDLE;
      end
      default:   nxt = ST_SLEEP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_SLEEP;
      ready_q <= 1'b0;
      ce_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
    end else begin
      state   <= nxt;
      ready_q <= (nxt == ST_IDLE) || (nxt == ST_SLEEP);
      ce_n_q  <= (nxt == ST_SLEEP);
      oe_n_q  <= (nxt != ST_ACCESS);
    end
  end

  assign req_ready = ready_q;
  assign ce_n      = ce_n_q;
  assign oe_n      = oe_n_q;

endmodule

// File: rtl/prom_rd_lane.sv
module prom_rd_lane #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_byte,
  input  logic              capture,
  input  logic              in_cycle,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-2:0] mem_addr,
  output logic              mem_byte_n,
  output logic              mem_lsb_out,
  output logic              mem_lsb_oe,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);

  localparam int unsigned LANE_W = DATA_W / 2;

  logic [ADDR_W-1:0] addr_q, addr_nxt;
  logic              byte_q, byte_nxt;
  logic [DATA_W-1:0] cap_d, data_q, data_nxt;
  logic              vld_q;

  // Upper lane is zeroed in byte mode; the top pin is an address there.
  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    if (g < LANE_W) begin : g_low
      assign cap_d[g] = mem_dq_in[g];
    end else begin : g_high
      assign cap_d[g] = mem_dq_in[g] & ~byte_q;
    end
  end

  always_comb begin
    addr_nxt = addr_q;
    byte_nxt = byte_q;
    data_nxt = data_q;
    if (accept) begin
      addr_nxt = req_addr;
      byte_nxt = req_byte;
    end
    if (capture) begin
      data_nxt = cap_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      byte_q <= 1'b0;
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      addr_q <= addr_nxt;
      byte_q <= byte_nxt;
      data_q <= data_nxt;
      vld_q  <= capture;
    end
  end

  assign mem_addr    = addr_q[ADDR_W-1:1];
  assign mem_byte_n  = ~byte_q;
  assign mem_lsb_out = addr_q[0];
  assign mem_lsb_oe  = byte_q & in_cycle;
  assign rsp_valid   = vld_q;
  assign rsp_data    = data_q;

endmodule

// File: rtl/prom_read_ctrl.sv
module prom_read_ctrl #(
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned T_ACC    = 10,
  parameter int unsigned T_OE     = 3,
  parameter int unsigned T_TURN   = 2,
  parameter int unsigned IDLE_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_byte,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-2:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_byte_n,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_lsb_out,
  output logic              mem_lsb_oe
);

  logic [1:0] rst_pipe;
  logic       srst_n;
  logic       accept, capture, in_cycle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign srst_n = rst_pipe[1];

  prom_rd_seq #(
    .T_ACC    (T_ACC),
    .T_OE     (T_OE),
    .T_TURN   (T_TURN),
    .IDLE_CYC (IDLE_CYC)
  ) seq_i (
    .clk       (clk),
    .rst_n     (srst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .accept    (accept),
    .capture   (capture),
    .in_cycle  (in_cycle),
    .ce_n      (mem_ce_n),
    .oe_n      (mem_oe_n)
  );

  prom_rd_lane #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) lane_i (
    .clk         (clk),
    .rst_n       (srst_n),
    .accept      (accept),
    .req_addr    (req_addr),
    .req_byte    (req_byte),
    .capture     (capture),
    .in_cycle    (in_cycle),
    .mem_dq_in   (mem_dq_in),
    .mem_addr    (mem_addr),
    .mem_byte_n  (mem_byte_n),
    .mem_lsb_out (mem_lsb_out),
    .mem_lsb_oe  (mem_lsb_oe),
    .rsp_valid   (rsp_valid),
    .rsp_data    (rsp_data)
  );

endmodule

// File: rtl/prom_rd_chk.sv
module prom_rd_chk #(
  parameter int unsigned MA_W = 23
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic [MA_W-1:0] mem_addr,
  input logic            mem_ce_n,
  input logic            mem_oe_n,
  input logic            mem_byte_n,
  input logic            mem_lsb_oe
);

  AST_OE_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_ce_n); // R11

  AST_WORD_PIN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n && mem_byte_n) |-> !mem_lsb_oe); // R5

  AST_FREE_BEFORE_OE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_oe_n) && mem_byte_n) |-> $past(!mem_lsb_oe)); // R5

  AST_BYTE_PIN_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n && !mem_byte_n) |-> mem_lsb_oe); // R4

  AST_SETUP_BEFORE_OE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> ($past(!mem_ce_n) && $stable(mem_addr) && $stable(mem_byte_n))); // R6

  AST_RSP_AT_OE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (mem_oe_n && $past(!mem_oe_n))); // R6

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |=> $stable(mem_addr)); // R8

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !req_ready); // R2

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R7

endmodule

bind prom_read_ctrl prom_rd_chk #(.MA_W(ADDR_W - 1)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .mem_addr   (mem_addr),
  .mem_ce_n   (mem_ce_n),
  .mem_oe_n   (mem_oe_n),
  .mem_byte_n (mem_byte_n),
  .mem_lsb_oe (mem_lsb_oe)
);

// File: tb/prom_read_ctrl_tb_top.sv
`timescale 1ns/1ps
module prom_read_ctrl_tb_top;

  localparam int unsigned T_ACC    = 10;
  localparam int unsigned T_OE     = 3;
  localparam int unsigned T_TURN   = 2;
  localparam int unsigned IDLE_CYC = 12;
  localparam int unsigned WAIT     = (T_ACC > T_OE + 1) ? T_ACC : T_OE + 1;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [23:0] req_addr;
  logic        req_byte;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic [22:0] mem_addr;
  logic        mem_ce_n, mem_oe_n, mem_byte_n;
  logic [15:0] mem_dq_in;
  logic        mem_lsb_out, mem_lsb_oe;

  int nchk = 0;
  int nerr = 0;

  prom_read_ctrl #(
    .T_ACC(T_ACC), .T_OE(T_OE), .T_TURN(T_TURN), .IDLE_CYC(IDLE_CYC)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_byte(req_byte), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_byte_n(mem_byte_n), .mem_dq_in(mem_dq_in),
    .mem_lsb_out(mem_lsb_out), .mem_lsb_oe(mem_lsb_oe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Memory content: one word per 23-bit word address.
  function automatic logic [15:0] wf(input logic [22:0] wa);
    return {wa[7:0] ^ 8'hC3, wa[15:8] ^ {1'b0, wa[22:16]}};
  endfunction

  // Timing model: counts edges over which pins stayed unchanged.
  logic [26:0] key_prev;
  logic        oe_prev;
  int          age, oe_age;
  logic [26:0] key_now;
  assign key_now = {mem_addr, mem_byte_n, mem_lsb_out, mem_lsb_oe, mem_ce_n};

  always @(posedge clk) begin
    key_prev <= key_now;
    oe_prev  <= mem_oe_n;
    if (key_now != key_prev) age <= 1;
    else if (age < 255) age <= age + 1;
    if (mem_oe_n) oe_age <= 0;
    else if (oe_prev) oe_age <= 1;
    else if (oe_age < 255) oe_age <= oe_age + 1;
  end

  logic        mdl_ok;
  logic [15:0] mdl_w;
  always_comb begin
    mdl_ok = !mem_ce_n && !mem_oe_n && (age + 1 >= int'(T_ACC)) && (oe_age + 1 >= int'(T_OE));
    mdl_w  = wf(mem_addr);
    if (mem_byte_n) begin
      mem_dq_in = mdl_ok ? mdl_w : 16'hA5A5;
    end else begin
      mem_dq_in[15]   = mem_lsb_oe ? mem_lsb_out : 1'b1;
      mem_dq_in[14:8] = 7'h55;
      if (mdl_ok && mem_lsb_oe) mem_dq_in[7:0] = mem_lsb_out ? mdl_w[15:8] : mdl_w[7:0];
      else                      mem_dq_in[7:0] = 8'hA5;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_data(input logic [23:0] a, input logic bm);
    logic [15:0] w;
    w = wf(a[23:1]);
    if (!bm) return w;
    return a[0] ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
  endfunction

  task automatic do_read(input logic [23:0] a, input logic bm);
    int lat, t;
    bit bad_rdy, bad_pin, bad_turn, bad_pulse;
    string rq;
    rq = bm ? "R4" : "R3";
    bad_rdy = 0; bad_pin = 0; bad_turn = 0; bad_pulse = 0;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_byte = bm;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!rsp_valid && lat < 200) begin
      if (req_ready) bad_rdy = 1;
      if (!mem_oe_n) begin
        if (mem_addr != a[23:1] || mem_byte_n != !bm || mem_lsb_oe != bm) bad_pin = 1;
        if (bm && mem_lsb_out != a[0]) bad_pin = 1;
      end
      @(negedge clk);
      lat++;
    end
    chk(lat == int'(WAIT), "R6 latency", lat, WAIT);
    chk(rsp_data == exp_data(a, bm), rq, rsp_data, exp_data(a, bm));
    chk(!bad_pin, bm ? "R4 pins" : "R5 pins", bad_pin, 0);
    chk(!bad_rdy, "R2 ready low", bad_rdy, 0);
    t = 0;
    do begin
      @(negedge clk);
      t++;
      if (t == 1 && rsp_valid) bad_pulse = 1;
      if (!req_ready && (!mem_oe_n || mem_addr != a[23:1])) bad_turn = 1;
    end while (!req_ready && t < 50);
    chk(!bad_pulse, "R7 pulse", bad_pulse, 0);
    chk(t == int'(T_TURN) && !bad_turn, "R8 turnaround", t, T_TURN);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_byte = 1'b0;
    repeat (5) @(negedge clk);
    chk(mem_ce_n && mem_oe_n && !mem_lsb_oe && !rsp_valid, "R1 pins in reset",
        {mem_ce_n, mem_oe_n, mem_lsb_oe, rsp_valid}, 4'b1100);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(req_ready && mem_ce_n && mem_oe_n && !mem_lsb_oe && !rsp_valid, "R1 after reset",
        {req_ready, mem_ce_n, mem_oe_n, mem_lsb_oe, rsp_valid}, 5'b11100);
  endtask

  task automatic t_words();
    do_read(24'h000000, 1'b0);
    do_read(24'h123457, 1'b0);
    do_read(24'hFFFFFE, 1'b0);
  endtask

  task automatic t_bytes();
    do_read(24'h000000, 1'b1);
    do_read(24'h000001, 1'b1);
    do_read(24'hABCDEF, 1'b1);
    do_read(24'hFFFFFF, 1'b1);
  endtask

  task automatic t_back_to_back();
    do_read(24'h0F0F0E, 1'b1);
    chk(!mem_ce_n, "R9 select low", mem_ce_n, 0);
    do_read(24'h0F0F0E, 1'b0);
    chk(!mem_ce_n, "R9 select low", mem_ce_n, 0);
    do_read(24'h80007F, 1'b1);
    chk(!mem_ce_n, "R9 select low", mem_ce_n, 0);
    do_read(24'h7FFF81, 1'b0);
  endtask

  task automatic t_standby();
    int t;
    t = 0;
    while (!mem_ce_n && t < 100) begin
      @(negedge clk);
      t++;
    end
    chk(t == int'(IDLE_CYC), "R10 standby delay", t, IDLE_CYC);
    chk(mem_ce_n && mem_oe_n && req_ready, "R10 standby state",
        {mem_ce_n, mem_oe_n, req_ready}, 3'b111);
    do_read(24'h5A5A5B, 1'b1);
    do_read(24'h3C3C3C, 1'b0);
  endtask

  initial begin
    t_reset();
    t_words();
    t_bytes();
    t_back_to_back();
    t_standby();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule